// File: doc/BRIEF.md
# Bridge Lock Admission Controller

This block sits on the near side of a two-port bus bridge. It looks at each transaction the near bus sends toward the far bus. For each one it decides whether the transaction goes into the bridge queue, gets a retry, or, for a repeated locked read whose data has arrived, gets its read data back. It also keeps the bridge's lock state: a locked read queued toward the far bus, the far-bus lock held by the bridge, and the near-bus lock owned by the locking master.

A request is a one-cycle strobe in the address phase. The bus lock line is active low. It is sampled in the address cycle and again one clock later, so the decision comes out as single-cycle response pulses two clock edges after the request strobe.

A locked sequence must open with a read. While that read is outstanding, every other transaction toward the far bus is turned away. A repeat of the locked read is only honoured when its address, command and byte enables match the captured ones. After the near-bus lock is established, only the owner's locked transactions are queued, and reads queued this way carry no prefetch permission. The lock ends when the lock line is high while the near bus is idle.

Top module: `bridge_lock_admit`

## Requirements
- R1: After reset all response pulses (`rsp_retry`, `rsp_data`, `q_push`, `q_prefetch_ok`, `q_locked`) and all lock flags (`lock_pend`, `lock_far_est`, `lock_near_est`) are 0, and the captured request fields are cleared.
- R2: A request counts as a locked attempt only when `lock_n` is 1 in the cycle of `req_valid` and 0 in the following cycle. Any other pair of levels makes it an unlocked attempt. The response pulses appear for one cycle, after the second clock edge following the `req_valid` cycle.
- R3: With no lock active, a locked far read while `far_locked_other` is 0 gives `rsp_retry`, `q_push` and `q_locked` all at 1 with `q_prefetch_ok` at 0. It captures address, command and byte enables and sets `lock_pend`.
- R4: With no lock active, a locked far attempt while `far_locked_other` is 1 gives `rsp_retry` only. Nothing is queued and no flag changes.
- R5: With no lock active, a locked far write gives `rsp_retry` only. Nothing is queued and no flag changes.
- R6: While `lock_pend` is 1, every far attempt is retried without `q_push`, except a matching locked repeat once the far lock is held. This includes unlocked traffic and locked reads to other addresses.
- R7: A locked repeat whose command, address and byte enables all equal the captured ones gives `rsp_data` (and no retry) only when `lock_far_est` is 1. This sets `lock_near_est` and clears `lock_pend`. A repeat that differs in any of these fields, or that arrives before the far lock, is retried.
- R8: A repeat that matches the captured fields but is not a locked attempt is retried.
- R9: While `lock_near_est` is 1, a locked far attempt is queued (`q_push`=1, `q_locked`=1, `q_prefetch_ok`=0, no retry), whether it is a read or a posted write. An unlocked far attempt is retried.
- R10: While `lock_near_est` is 1, the lock is released only in a cycle with `lock_n`=1 and `bus_idle`=1. After that all flags are 0 and an unlocked far read is queued with `q_prefetch_ok`=1.
- R11: A request with `req_far`=0 gives no response pulse and changes no flag.
- R12: With no lock active, an unlocked far attempt is queued with no retry. `q_prefetch_ok` equals `req_read` and `q_locked` is 0.
- R13: `far_done` while `lock_pend` is 1 sets `lock_far_est` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Address-phase strobe of a near-bus transaction |
| req_far | input | 1 | Transaction targets the far bus |
| req_read | input | 1 | Transaction is a read (0 = posted write) |
| req_cmd | input | CMD_W | Bus command code, compared on repeats |
| req_addr | input | ADDR_W | Transaction address |
| req_be | input | BE_W | Byte enables |
| lock_n | input | 1 | Sampled near-bus lock line, active low |
| bus_idle | input | 1 | Near bus is idle |
| far_locked_other | input | 1 | Far bus locked by a master not using the bridge |
| far_done | input | 1 | Queued locked read completed on the far bus |
| rsp_retry | output | 1 | Retry pulse to the initiator |
| rsp_data | output | 1 | Read-data-return pulse for the locked repeat |
| q_push | output | 1 | Enqueue pulse toward the far bus |
| q_prefetch_ok | output | 1 | Queued read may be prefetched |
| q_locked | output | 1 | Queued transaction belongs to the locked sequence |
| lock_pend | output | 1 | Locked read captured, near lock not yet held |
| lock_far_est | output | 1 | Bridge holds the far-bus lock |
| lock_near_est | output | 1 | Near-bus lock established through the bridge |

## Verification
The bench targets the two-cycle lock signature. A design that samples the line in only one cycle would treat a master that simply holds the lock low as a new locking master. It varies the command, address and byte enables of repeats one at a time, which catches a comparator that ignores a field and so hands data to the wrong request. It sends matching repeats before the far completion and without the lock signature; a design that answers these with data would break the lock. It holds the lock line high on a busy bus to catch an early release, and it sends a locked write first and a locked read under a far lock held elsewhere; a design that gets these wrong would queue a sequence it must refuse.

// File: rtl/lock_adm_pkg.sv
package lock_adm_pkg;

   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_PEND  = 2'd1,
      LK_READY = 2'd2,
      LK_HELD  = 2'd3
   } lk_state_t;

   typedef struct packed {
      logic retry;
      logic data;
      logic push;
      logic prefetch;
      logic locked;
   } lk_resp_t;

   localparam lk_resp_t LK_RESP_NONE = '{default: 1'b0};

endpackage

// File: rtl/lock_seq_stage.sv
module lock_seq_stage #(
   parameter int ADDR_W = 32,
   parameter int CMD_W  = 4,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_far,
   input  logic              req_read,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic              lock_n,
   output logic              att_valid,
   output logic              att_far,
   output logic              att_read,
   output logic              att_locked,
   output logic [CMD_W-1:0]  att_cmd,
   output logic [ADDR_W-1:0] att_addr,
   output logic [BE_W-1:0]   att_be
);

   logic addr_lock_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         att_valid    <= 1'b0;
         att_far      <= 1'b0;
         att_read     <= 1'b0;
         att_cmd      <= '0;
         att_addr     <= '0;
         att_be       <= '0;
         addr_lock_hi <= 1'b0;
      end else begin
         att_valid <= req_valid;
         if (req_valid) begin
            att_far      <= req_far;
            att_read     <= req_read;
            att_cmd      <= req_cmd;
            att_addr     <= req_addr;
            att_be       <= req_be;
            addr_lock_hi <= lock_n;
         end
      end
   end

   // high in the address phase, low one clock after it
   assign att_locked = att_valid & addr_lock_hi & ~lock_n;

   // R2: a locked attempt requires the line high one cycle earlier
   p_signature_r2: assert property (@(posedge clk) disable iff (!rst_n)
      att_locked |-> $past(lock_n) && $past(req_valid));

endmodule

// File: rtl/lock_req_match.sv
module lock_req_match #(
   parameter int  ADDR_W   = 32,
   parameter int  CMD_W    = 4,
   parameter int  BE_W     = 4,
   parameter bit  MATCH_BE = 1'b1
) (
   input  logic [CMD_W-1:0]  a_cmd,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [BE_W-1:0]   a_be,
   input  logic [CMD_W-1:0]  c_cmd,
   input  logic [ADDR_W-1:0] c_addr,
   input  logic [BE_W-1:0]   c_be,
   output logic              hit
);

   logic base_hit;
   assign base_hit = (a_cmd == c_cmd) && (a_addr == c_addr);

   generate
      if (MATCH_BE) begin : g_with_be
         assign hit = base_hit && (a_be == c_be);
      end else begin : g_no_be
         logic be_unused;
         assign be_unused = ^{a_be, c_be};
         assign hit = base_hit | (be_unused & 1'b0);
      end
   endgenerate

endmodule

// File: rtl/lock_adm_fsm.sv
module lock_adm_fsm
   import lock_adm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CMD_W  = 4,
   parameter int BE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              att_valid,
   input  logic              att_far,
   input  logic              att_read,
   input  logic              att_locked,
   input  logic [CMD_W-1:0]  att_cmd,
   input  logic [ADDR_W-1:0] att_addr,
   input  logic [BE_W-1:0]   att_be,
   input  logic              hit,
   input  logic              lock_n,
   input  logic              bus_idle,
   input  logic              far_locked_other,
   input  logic              far_done,
   output logic [CMD_W-1:0]  cap_cmd,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [BE_W-1:0]   cap_be,
   output lk_resp_t          resp,
   output lk_state_t         state
);

   lk_state_t nxt;
   lk_resp_t  d;
   logic      cap_en;
   logic      far_att;

   assign far_att = att_valid & att_far;

   always_comb begin
      nxt    = state;
      d      = LK_RESP_NONE;
      cap_en = 1'b0;
      unique case (state)
         LK_IDLE: begin
            if (far_att) begin
               if (att_locked) begin
                  d.retry = 1'b1;
                  if (att_read && !far_locked_other) begin
                     d.push   = 1'b1;
                     d.locked = 1'b1;
                     cap_en   = 1'b1;
                     nxt      = LK_PEND;
                  end
               end else begin
                  d.push     = 1'b1;
                  d.prefetch = att_read;
               end
            end
         end
         LK_PEND, LK_READY: begin
            if (state == LK_PEND && far_done) nxt = LK_READY;
            if (far_att) begin
               if (state == LK_READY && att_locked && hit) begin
                  d.data = 1'b1;
                  nxt    = LK_HELD;
               end else begin
                  d.retry = 1'b1;
               end
            end
         end
         LK_HELD: begin
            if (far_att) begin
               if (att_locked) begin
                  d.push   = 1'b1;
                  d.locked = 1'b1;
               end else begin
                  d.retry = 1'b1;
               end
            end
            if (lock_n && bus_idle) nxt = LK_IDLE;
         end
         default: nxt = LK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LK_IDLE;
         resp     <= LK_RESP_NONE;
         cap_cmd  <= '0;
         cap_addr <= '0;
         cap_be   <= '0;
      end else begin
         state <= nxt;
         resp  <= d;
         if (cap_en) begin
            cap_cmd  <= att_cmd;
            cap_addr <= att_addr;
            cap_be   <= att_be;
         end
      end
   end

   // R6: while the locked read is outstanding nothing else is queued
   p_pend_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_PEND) && far_att |=> resp.retry && !resp.push);

   // R4: a far lock held elsewhere refuses the sequence
   p_far_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_IDLE) && far_att && att_locked && far_locked_other
      |=> resp.retry && !resp.push && (state == LK_IDLE));

   // R10: release needs the line high on an idle bus
   p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_HELD) && !(lock_n && bus_idle) |=> (state == LK_HELD));

   // R7: data is never returned together with a retry
   p_data_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp.data |-> !resp.retry && !resp.push);

endmodule

// File: rtl/bridge_lock_admit.sv
module bridge_lock_admit
   import lock_adm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CMD_W    = 4,
   parameter int BE_W     = 4,
   parameter bit MATCH_BE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_far,
   input  logic              req_read,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BE_W-1:0]   req_be,
   input  logic              lock_n,
   input  logic              bus_idle,
   input  logic              far_locked_other,
   input  logic              far_done,
   output logic              rsp_retry,
   output logic              rsp_data,
   output logic              q_push,
   output logic              q_prefetch_ok,
   output logic              q_locked,
   output logic              lock_pend,
   output logic              lock_far_est,
   output logic              lock_near_est
);

   generate
      if (ADDR_W < 1 || CMD_W < 1 || BE_W < 1) begin : g_bad_width
         $error("bridge_lock_admit: field widths must be positive");
      end
   endgenerate

   logic              att_valid, att_far, att_read, att_locked, hit;
   logic [CMD_W-1:0]  att_cmd, cap_cmd;
   logic [ADDR_W-1:0] att_addr, cap_addr;
   logic [BE_W-1:0]   att_be, cap_be;
   lk_resp_t          resp;
   lk_state_t         state;

   lock_seq_stage #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BE_W(BE_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_far(req_far), .req_read(req_read),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
      .lock_n(lock_n),
      .att_valid(att_valid), .att_far(att_far), .att_read(att_read),
      .att_locked(att_locked), .att_cmd(att_cmd), .att_addr(att_addr),
      .att_be(att_be)
   );

   lock_req_match #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BE_W(BE_W),
                    .MATCH_BE(MATCH_BE)) u_match (
      .a_cmd(att_cmd), .a_addr(att_addr), .a_be(att_be),
      .c_cmd(cap_cmd), .c_addr(cap_addr), .c_be(cap_be),
      .hit(hit)
   );

   lock_adm_fsm #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .BE_W(BE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .att_valid(att_valid), .att_far(att_far), .att_read(att_read),
      .att_locked(att_locked), .att_cmd(att_cmd), .att_addr(att_addr),
      .att_be(att_be), .hit(hit),
      .lock_n(lock_n), .bus_idle(bus_idle),
      .far_locked_other(far_locked_other), .far_done(far_done),
      .cap_cmd(cap_cmd), .cap_addr(cap_addr), .cap_be(cap_be),
      .resp(resp), .state(state)
   );

   assign rsp_retry     = resp.retry;
   assign rsp_data      = resp.data;
   assign q_push        = resp.push;
   assign q_prefetch_ok = resp.prefetch;
   assign q_locked      = resp.locked;
   assign lock_pend     = (state == LK_PEND) || (state == LK_READY);
   assign lock_far_est  = (state == LK_READY) || (state == LK_HELD);
   assign lock_near_est = (state == LK_HELD);

   // R7: the near lock only follows a held far lock
   p_near_after_far_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_near_est) |-> $past(lock_far_est) && rsp_data);

   // R9: reads of the locked sequence are never prefetched
   p_locked_no_prefetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      q_push && $past(lock_near_est) |-> !q_prefetch_ok);

endmodule

// File: tb/bridge_lock_admit_test.sv
`timescale 1ns/1ps
module bridge_lock_admit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_far = 1'b0, req_read = 1'b0;
   logic [3:0]  req_cmd = '0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic        lock_n = 1'b1, bus_idle = 1'b1;
   logic        far_locked_other = 1'b0, far_done = 1'b0;
   logic        rsp_retry, rsp_data, q_push, q_prefetch_ok, q_locked;
   logic        lock_pend, lock_far_est, lock_near_est;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bridge_lock_admit uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_far(req_far), .req_read(req_read),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be),
      .lock_n(lock_n), .bus_idle(bus_idle),
      .far_locked_other(far_locked_other), .far_done(far_done),
      .rsp_retry(rsp_retry), .rsp_data(rsp_data), .q_push(q_push),
      .q_prefetch_ok(q_prefetch_ok), .q_locked(q_locked),
      .lock_pend(lock_pend), .lock_far_est(lock_far_est),
      .lock_near_est(lock_near_est)
   );

   // response order: retry, data, push, prefetch, locked
   task automatic chk_rsp(input string r, input logic [4:0] exp);
      logic [4:0] act;
      act = {rsp_retry, rsp_data, q_push, q_prefetch_ok, q_locked};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s response act=%b exp=%b", r, act, exp);
      end
   endtask

   // flag order: pend, far_est, near_est
   task automatic chk_flags(input string r, input logic [2:0] exp);
      logic [2:0] act;
      act = {lock_pend, lock_far_est, lock_near_est};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s flags act=%b exp=%b", r, act, exp);
      end
   endtask

   // drives one request; lk_a/lk_b are lock_n in address cycle / next cycle;
   // returns at the negedge where the response pulse is visible
   task automatic send(input logic far, input logic rd, input logic [3:0] cmd,
                       input logic [31:0] addr, input logic [3:0] be,
                       input logic lk_a, input logic lk_b);
      @(negedge clk);
      req_valid = 1'b1; req_far = far; req_read = rd;
      req_cmd = cmd; req_addr = addr; req_be = be; lock_n = lk_a;
      @(negedge clk);
      req_valid = 1'b0; lock_n = lk_b;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk_rsp("R1", 5'b00000);
      chk_flags("R1", 3'b000);
   endtask

   task automatic t_unlocked_idle();
      send(1, 1, 4'h6, 32'h100, 4'hF, 1, 1);
      chk_rsp("R12 read", 5'b00110);
      send(1, 0, 4'h7, 32'h104, 4'h3, 1, 1);
      chk_rsp("R12 write", 5'b00100);
      send(1, 1, 4'h6, 32'h108, 4'hF, 0, 0); lock_n = 1'b1;
      chk_rsp("R2 held low", 5'b00110);
      chk_flags("R2", 3'b000);
   endtask

   task automatic t_near_only();
      send(0, 1, 4'h6, 32'h200, 4'hF, 1, 0); lock_n = 1'b1;
      chk_rsp("R11", 5'b00000);
      chk_flags("R11", 3'b000);
   endtask

   task automatic t_first_write();
      send(1, 0, 4'h7, 32'h300, 4'hF, 1, 0); lock_n = 1'b1;
      chk_rsp("R5", 5'b10000);
      chk_flags("R5", 3'b000);
   endtask

   task automatic t_far_busy();
      far_locked_other = 1'b1;
      send(1, 1, 4'h6, 32'h400, 4'hF, 1, 0); lock_n = 1'b1;
      chk_rsp("R4", 5'b10000);
      chk_flags("R4", 3'b000);
      far_locked_other = 1'b0;
   endtask

   task automatic t_lock_flow();
      send(1, 1, 4'h6, 32'hA00, 4'h5, 1, 0); lock_n = 1'b1;
      chk_rsp("R3", 5'b10101);
      chk_flags("R3", 3'b100);
      send(1, 1, 4'h6, 32'h500, 4'hF, 1, 1);
      chk_rsp("R6 unlocked", 5'b10000);
      send(1, 1, 4'h6, 32'hB00, 4'h5, 1, 0); lock_n = 1'b1;
      chk_rsp("R6 other lock", 5'b10000);
      send(1, 1, 4'h6, 32'hA00, 4'h5, 1, 0); lock_n = 1'b1;
      chk_rsp("R7 early", 5'b10000);
      @(negedge clk); far_done = 1'b1;
      @(negedge clk); far_done = 1'b0;
      chk_flags("R13", 3'b110);
      send(1, 1, 4'h6, 32'hA00, 4'h5, 1, 1);
      chk_rsp("R8", 5'b10000);
      send(1, 1, 4'h6, 32'hA00, 4'h7, 1, 0); lock_n = 1'b1;
      chk_rsp("R7 be", 5'b10000);
      send(1, 1, 4'hE, 32'hA00, 4'h5, 1, 0); lock_n = 1'b1;
      chk_rsp("R7 cmd", 5'b10000);
      send(1, 1, 4'h6, 32'hA04, 4'h5, 1, 0); lock_n = 1'b1;
      chk_rsp("R7 addr", 5'b10000);
      chk_flags("R7 hold", 3'b110);
      bus_idle = 1'b0;
      send(1, 1, 4'h6, 32'hA00, 4'h5, 1, 0);
      chk_rsp("R7 match", 5'b01000);
      chk_flags("R7 near", 3'b011);
      send(1, 0, 4'h7, 32'hA10, 4'hF, 1, 0);
      chk_rsp("R9 write", 5'b00101);
      send(1, 1, 4'h6, 32'hA20, 4'hF, 1, 0);
      chk_rsp("R9 read", 5'b00101);
      send(1, 1, 4'h6, 32'h600, 4'hF, 0, 0);
      chk_rsp("R9 other", 5'b10000);
      @(negedge clk); lock_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_flags("R10 busy", 3'b011);
      bus_idle = 1'b1;
      @(negedge clk);
      chk_flags("R10 release", 3'b000);
      send(1, 1, 4'h6, 32'h700, 4'hF, 1, 1);
      chk_rsp("R10 after", 5'b00110);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_unlocked_idle();
      t_near_only();
      t_first_write();
      t_far_busy();
      t_lock_flow();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule